// File: doc/BRIEF.md
# Self-Timed Carry Ripple Adder with Completion Detection

This block adds two unsigned operands and reports by itself when the result is ready, instead of reserving the worst-case carry delay for every addition. Every carry between bit positions is held as a two-wire code. The code starts empty, meaning "not yet known", and settles once to a definite 0 or 1. A completion detector watches all of these codes and raises `done` in the first cycle in which none is empty. The number of cycles an addition takes therefore follows the longest carry chain that the operands actually produce.

Carry settling is modelled one ripple step per clock edge. A position whose two operand bits are equal fixes its carry-out on the first evaluation edge, because it either kills or generates a carry. A position whose bits differ copies its carry-in one edge after that carry-in has settled. The carry into bit 0 is held as its own two-wire code, and it settles to 0 on the first evaluation edge. After the result has been presented, every code goes back to empty (the spacer phase) before the adder accepts another operation.

A user raises `start` with the operands while `busy` is low. The user waits for the single-cycle `done` pulse and takes `sum` and `cout` in that cycle.

Top module: `dr_ripple_adder`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: In the cycle in which `done` is high, {`cout`, `sum`} equals `opa` + `opb` as a WIDTH+1-bit unsigned sum. The operands used are the ones captured when the operation was accepted.
- R3: Each carry is held as a pair {one-rail, zero-rail}. The code 00 means empty, 01 means carry 0 and 10 means carry 1. Both rails are never high at once. During evaluation, a pair that has settled keeps its value.
- R4: On the first evaluation edge, every position with equal operand bits settles its carry-out, and so does the carry-in pair of bit 0. A position with differing bits settles on the edge after its carry-in settles.
- R5: `done` rises exactly when every carry pair has settled. This happens k cycles after the edge that accepted `start`, where k is 1 plus the longest run of adjacent bit positions whose operand bits differ.
- R6: Adding 1 to all-ones takes WIDTH cycles. Adding 0 to all-ones takes WIDTH+1 cycles, which is the longest possible latency.
- R7: Operands with no differing bit (for example equal operands) complete in 1 cycle.
- R8: `done` stays high for exactly one cycle per operation.
- R9: On the edge that ends the `done` cycle, all carry pairs return to empty. `busy` stays high for one further (spacer) cycle and is low after it.
- R10: A `start` seen while `busy` is high has no effect. It changes neither the operands in use nor the result, and no extra `done` follows it.
- R11: `start` sampled high while `busy` is low captures `opa` and `opb`, and `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an addition; taken only while idle |
| opa | input | WIDTH | First operand, captured with `start` |
| opb | input | WIDTH | Second operand, captured with `start` |
| sum | output | WIDTH | Sum bits, valid while `done` is high |
| cout | output | 1 | Carry out of the top bit, valid while `done` is high |
| done | output | 1 | One-cycle pulse: every carry has settled |
| busy | output | 1 | An operation or its spacer phase is in progress |

## Verification
Some properties are checked on every cycle: the legality of each carry code, the rule that a settled carry never changes, the settling of equal-bit positions on the first edge, the arithmetic result at `done`, the shape of the `done` pulse, the spacer clear and the upper bound on evaluation length. Other behaviour is shown only by the bench's scenarios. These cover the exact operand-dependent latency for directed and random operands, the extreme cases of all-ones plus one and all-ones plus zero, and the rejection of `start` during evaluation and during the spacer phase.

// File: rtl/dr_add_pkg.sv
package dr_add_pkg;

    // Two-wire carry code: {hi, lo} = 00 empty, 01 carry 0, 10 carry 1
    typedef struct packed {
        logic hi;
        logic lo;
    } rail_t;

    localparam rail_t RAIL_EMPTY = '{hi: 1'b0, lo: 1'b0};

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EVAL   = 2'd1,
        PH_SPACER = 2'd2
    } phase_t;

    function automatic logic rail_valid(input rail_t r);
        return r.hi | r.lo;
    endfunction

    function automatic rail_t rail_of(input logic v);
        rail_t r;
        r.hi = v;
        r.lo = ~v;
        return r;
    endfunction

endpackage

// File: rtl/dr_carry_cell.sv
module dr_carry_cell
    import dr_add_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  eval_en,
    input  logic  bit_a,
    input  logic  bit_b,
    input  rail_t cin,
    output rail_t cout_q
);

    rail_t nxt;

    always_comb begin
        nxt = cout_q;
        if (clr) begin
            nxt = RAIL_EMPTY;
        end else if (eval_en && !rail_valid(cout_q)) begin
            if (bit_a == bit_b) begin
                // kill (0,0) or generate (1,1): independent of carry-in
                nxt = rail_of(bit_a);
            end else if (rail_valid(cin)) begin
                // propagate: pass the settled carry-in on
                nxt = cin;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cout_q <= RAIL_EMPTY;
        else     cout_q <= nxt;
    end

endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
    parameter int W = 33
) (
    input  logic [W-1:0] rail_lo,
    input  logic [W-1:0] rail_hi,
    output logic         all_set,
    output logic         all_clear
);

    logic [W-1:0] settled;

    assign settled   = rail_lo | rail_hi;
    assign all_set   = &settled;
    assign all_clear = ~|settled;

endmodule

// File: rtl/dr_ctrl.sv
module dr_ctrl
    import dr_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic all_set,
    input  logic all_clear,
    output logic load_en,
    output logic eval_en,
    output logic clr_en,
    output logic done,
    output logic busy
);

    phase_t state_q, state_d;

    assign load_en = (state_q == PH_IDLE) && start;
    assign eval_en = (state_q == PH_EVAL);
    assign done    = eval_en && all_set;
    assign clr_en  = done || (state_q == PH_SPACER);
    assign busy    = (state_q != PH_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (start)     state_d = PH_EVAL;
            PH_EVAL:   if (all_set)   state_d = PH_SPACER;
            PH_SPACER: if (all_clear) state_d = PH_IDLE;
            default:                  state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/dr_ripple_adder.sv
module dr_ripple_adder
    import dr_add_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done,
    output logic             busy
);

    // cell 0 holds the carry into bit 0; cell j>0 holds the carry out of bit j-1
    localparam int CELLS = WIDTH + 1;

    logic [WIDTH-1:0] opa_q, opb_q;
    logic [CELLS-1:0] ext_a, ext_b;
    logic [CELLS-1:0] rail_lo, rail_hi;
    logic             load_en, eval_en, clr_en, all_set, all_clear;
    rail_t            chain [CELLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (load_en) begin
            opa_q <= opa;
            opb_q <= opb;
        end
    end

    // bit 0 of the extension is a kill pair, so the carry-in settles to 0
    assign ext_a = {opa_q, 1'b0};
    assign ext_b = {opb_q, 1'b0};

    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        rail_t cin_w;
        if (j == 0) begin : g_first
            assign cin_w = RAIL_EMPTY;
        end else begin : g_next
            assign cin_w = chain[j-1];
        end

        dr_carry_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_en),
            .eval_en(eval_en),
            .bit_a  (ext_a[j]),
            .bit_b  (ext_b[j]),
            .cin    (cin_w),
            .cout_q (chain[j])
        );

        assign rail_lo[j] = chain[j].lo;
        assign rail_hi[j] = chain[j].hi;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = opa_q[i] ^ opb_q[i] ^ chain[i].hi;
    end

    assign cout = chain[WIDTH].hi;

    dr_completion #(.W(CELLS)) u_detect (
        .rail_lo  (rail_lo),
        .rail_hi  (rail_hi),
        .all_set  (all_set),
        .all_clear(all_clear)
    );

    dr_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .all_set  (all_set),
        .all_clear(all_clear),
        .load_en  (load_en),
        .eval_en  (eval_en),
        .clr_en   (clr_en),
        .done     (done),
        .busy     (busy)
    );

endmodule

// File: rtl/dr_ripple_adder_chk.sv
module dr_ripple_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             eval_ph,
    input logic             clr,
    input logic [WIDTH-1:0] opa_q,
    input logic [WIDTH-1:0] opb_q,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH:0]   rail_lo,
    input logic [WIDTH:0]   rail_hi
);

    localparam int CW = $clog2(WIDTH + 3) + 1;

    logic [CW-1:0] eval_cnt;
    logic [WIDTH:0] settled, same_bits;

    assign settled   = rail_lo | rail_hi;
    assign same_bits = ~({opa_q, 1'b0} ^ {opb_q, 1'b0});

    always_ff @(posedge clk) begin
        if (rst || !eval_ph) eval_cnt <= '0;
        else                 eval_cnt <= eval_cnt + 1'b1;
    end

    assert_no_double_rail_R3: assert property (@(posedge clk) disable iff (rst)
        (rail_lo & rail_hi) == '0);

    assert_settled_holds_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(eval_ph) && !$past(clr) && !$past(rst))
        |-> (((settled & $past(settled)) == $past(settled))
             && ((rail_hi & $past(rail_hi)) == $past(rail_hi))));

    assert_first_edge_settles_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(eval_ph) && !$past(clr) && !$past(rst) && ($past(settled) == '0))
        |-> ((settled & same_bits) == same_bits));

    assert_done_when_settled_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (settled == '1));

    assert_no_early_done_R5: assert property (@(posedge clk) disable iff (rst)
        (eval_ph && (settled != '1)) |-> !done);

    assert_result_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ({cout, sum} == ({1'b0, opa_q} + {1'b0, opb_q})));

    assert_eval_bound_R6: assert property (@(posedge clk) disable iff (rst)
        eval_ph |-> (eval_cnt <= CW'(WIDTH + 1)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_spacer_clear_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (busy && (settled == '0)));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(opa_q) && $stable(opb_q)));

    assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .eval_ph(eval_en),
    .clr    (clr_en),
    .opa_q  (opa_q),
    .opb_q  (opb_q),
    .sum    (sum),
    .cout   (cout),
    .rail_lo(rail_lo),
    .rail_hi(rail_hi)
);

// File: tb/dr_ripple_adder_bench.sv
module dr_ripple_adder_bench;

    localparam int W = 32;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] sum;
    logic         cout;
    logic         done;
    logic         busy;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    dr_ripple_adder #(.WIDTH(W)) u_dr_ripple_adder (
        .clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb),
        .sum(sum), .cout(cout), .done(done), .busy(busy)
    );

    always #10ns clk = ~clk;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 1 + longest run of adjacent differing operand bits
    function automatic int exp_lat(input logic [W-1:0] x, input logic [W-1:0] y);
        int run = 0;
        int best = 0;
        for (int i = 0; i < W; i++) begin
            if (x[i] ^ y[i]) run++;
            else run = 0;
            if (run > best) best = run;
        end
        return best + 1;
    endfunction

    // called at the negedge after the accept edge; counts cycles until done
    task automatic wait_done(output int cyc, output bit seen);
        cyc = 0;
        seen = 0;
        while (!seen && cyc < W + 4) begin
            if (done) seen = 1;
            else begin
                @(posedge clk);
                @(negedge clk);
                cyc++;
            end
        end
    endtask

    task automatic check_tail(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk(!done, {tag, " R8 done pulse"}, longint'(done), 0);
        chk(busy, {tag, " R9 spacer busy"}, longint'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        chk(!busy, {tag, " R9 idle after spacer"}, longint'(busy), 0);
    endtask

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        int cyc;
        bit seen;
        logic [W:0] exp_sum;
        exp_sum = {1'b0, x} + {1'b0, y};
        @(negedge clk);
        opa = x;
        opb = y;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy, {tag, " R11 busy after accept"}, longint'(busy), 1);
        wait_done(cyc, seen);
        chk(seen && cyc == exp_lat(x, y), {tag, " latency"}, longint'(cyc), longint'(exp_lat(x, y)));
        chk({cout, sum} == exp_sum, {tag, " R2 sum"}, longint'({cout, sum}), longint'(exp_sum));
        check_tail(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy, "R1 busy at reset", longint'(busy), 0);
        chk(!done, "R1 done at reset", longint'(done), 0);
    endtask

    task automatic t_best();
        run_op(32'h0000_0000, 32'h0000_0000, "R7 zero+zero");
        run_op(32'h1234_5678, 32'h1234_5678, "R7 equal operands");
        run_op('1, '1, "R7 ones+ones");
        run_op(32'h0000_0001, 32'h0000_0000, "R5 one+zero");
    endtask

    task automatic t_worst();
        run_op('1, 32'h0000_0001, "R6 ones+one");
        run_op('1, 32'h0000_0000, "R6 ones+zero");
        run_op(32'h8000_0000, 32'h8000_0000, "R4 top generate");
    endtask

    task automatic t_directed();
        run_op(32'h0000_00F0, 32'h0000_000F, "R4 low run");
        run_op(32'h00FF_0000, 32'h0100_FFFF, "R4 mid run");
        run_op(32'hAAAA_AAAA, 32'h5555_5555, "R5 full alternation");
        run_op(32'hF0F0_0F0F, 32'h0F00_F0F1, "R5 split runs");
    endtask

    task automatic t_random();
        for (int k = 0; k < 24; k++) begin
            run_op($urandom(), $urandom(), "R5 random");
        end
    endtask

    // start held high with other operands during evaluation
    task automatic t_busy_ignore();
        int cyc;
        bit seen;
        logic [W-1:0] x = '1;
        logic [W-1:0] y = 32'h0000_0001;
        @(negedge clk);
        opa = x;
        opb = y;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        opa = 32'h0000_0005;
        opb = 32'h0000_0007;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        wait_done(cyc, seen);
        cyc += 3;
        chk(seen && cyc == W, "R10 latency unaffected", longint'(cyc), longint'(W));
        chk({cout, sum} == ({1'b0, x} + {1'b0, y}), "R10 result unaffected",
            longint'({cout, sum}), longint'({1'b0, x} + {1'b0, y}));
        check_tail("R10 busy");
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(!done && !busy, "R10 no queued op", longint'({busy, done}), 0);
        end
    endtask

    // start raised in the done cycle and held through the spacer cycle
    task automatic t_spacer_ignore();
        int cyc;
        bit seen;
        @(negedge clk);
        opa = 32'h0000_0003;
        opb = 32'h0000_0001;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc, seen);
        chk(seen && cyc == 2, "R5 short op latency", longint'(cyc), 2);
        opa = 32'h0000_0009;
        opb = 32'h0000_0009;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(busy && !done, "R9 spacer with start", longint'({busy, done}), 2);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R10 spacer start ignored", longint'(busy), 0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(!done && !busy, "R10 no op from spacer start", longint'({busy, done}), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_best();
        t_worst();
        t_directed();
        t_random();
        t_busy_ignore();
        t_spacer_ignore();
        summary();
    end

endmodule